// File: doc/BRIEF.md
# Processor Exception Cause and Vector Unit

This block sits beside a processor pipeline and decides, one cycle at a time, whether an exception must be taken. Each cycle it reads the result of the instruction fetch translation, the external interrupt line, a set of decode flags for the instruction in execution, and three machine-state bits: user mode, floating-point enable and external enable. It also holds its own down-counting decrementer. When at least one cause is present, the block picks the most urgent one by a fixed priority. On the following clock it gives a single-cycle take pulse, the 20-bit vector offset of the winner and a status word whose bits name the exact cause.

The surrounding core uses the take pulse to flush and redirect to the vector, and copies the status word into its save register. Address translation, trap-condition evaluation, flushing and state save are done elsewhere. The trap result arrives here as a decode flag.

Top module: `exc_vector_unit`

## Requirements
- R1: The vector offset is 0x00400 for fetch fault, 0x00500 for external interrupt, 0x00600 for alignment, 0x00700 for program, 0x00800 for floating-point unavailable, 0x00900 for decrementer and 0x00C00 for system call. No offset in 0x00A00..0x00BFF ever appears.
- R2: A fetch with `fetch_valid_i` raises a fetch fault when translation misses (status bit 1), when the segment is direct-store (status bit 3), or when protection forbids reading (status bit 4). All bits that apply are set together.
- R3: Fetch protection forbids reading exactly when the selected key is 1 and the page protection field is 2'b00. Every other key/protection pair allows the fetch.
- R4: An external interrupt is requested only while `ext_irq_i` and `msr_ee_i` are both 1.
- R5: With `instr_valid_i`, an illegal opcode raises a program exception with status bit 12. No exception is raised when the op is flagged as an optional no-op.
- R6: A privileged op in user mode (`msr_pr_i`=1) raises a program exception with status bit 13. So does a special-register move whose register number is invalid and has its top bit set. Neither case raises anything in supervisor mode, and neither does such a move with a top bit of 0.
- R7: A met trap condition raises a program exception with status bit 14. When several program causes coincide, all of their bits are set.
- R8: A floating-point op raises floating-point unavailable when `msr_fp_i`=0, and never when it is 1.
- R9: The 32-bit decrementer loads on write and otherwise drops by one per tick. A request latches when a tick moves its top bit from 0 to 1. The latch is taken only while `msr_ee_i`=1, and it is held until it is taken or the decrementer is written.
- R10: An alignment flag and a system call op each raise their own exception. Their status word is zero.
- R11: When causes coincide, the winner is chosen in this order: fetch fault, program, floating-point unavailable, alignment, system call, external interrupt, decrementer.
- R12: `take_o`, `vec_off_o` and `cause_o` are registered and show the decision one clock after the inputs. When no exception is taken, all three are zero. External and decrementer exceptions carry a zero status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid_i | input | 1 | A fetch result is present this cycle |
| fetch_xlate_miss_i | input | 1 | Fetch address could not be translated |
| fetch_dseg_i | input | 1 | Fetch targets a direct-store segment |
| fetch_key_i | input | 1 | Segment key selected for the current privilege |
| fetch_pp_i | input | 2 | Page protection field of the fetch page |
| ext_irq_i | input | 1 | External interrupt line |
| msr_ee_i | input | 1 | External-enable machine-state bit |
| msr_pr_i | input | 1 | User-mode machine-state bit |
| msr_fp_i | input | 1 | Floating-point enable machine-state bit |
| instr_valid_i | input | 1 | Decode flags below are valid |
| op_illegal_i | input | 1 | Illegal opcode or opcode combination |
| op_opt_nop_i | input | 1 | Optional op treated as a no-op |
| op_priv_i | input | 1 | Privileged op |
| op_spr_move_i | input | 1 | Special-register move |
| op_spr_bad_i | input | 1 | Special-register number is invalid |
| op_spr_top_i | input | 1 | Top bit of the special-register number |
| op_trap_hit_i | input | 1 | Trap condition is met |
| op_fp_i | input | 1 | Floating-point op |
| op_misalign_i | input | 1 | Alignment fault on the operand |
| op_sc_i | input | 1 | System call op |
| dec_tick_i | input | 1 | Decrementer count enable |
| dec_wr_i | input | 1 | Decrementer write strobe |
| dec_wdata_i | input | 32 | Decrementer write value |
| take_o | output | 1 | Exception taken (one cycle) |
| vec_off_o | output | 20 | Vector offset of the taken exception |
| cause_o | output | 32 | Status word with cause bits |
| dec_value_o | output | 32 | Current decrementer value |

## Verification
On every cycle, the assertions check these rules: the vector stays legal, the outputs are zero on idle cycles, an external take needs the enable in the previous cycle, floating-point unavailable is never taken with the enable set, a fetch fault always wins, and the decrementer keeps both its count and its latched request. The full priority chain, the exact cause-bit combinations, and the masking cases can only be shown by the bench's scenarios, which compare against a behavioural model each cycle. The masking cases are optional no-ops, supervisor mode, and special-register moves with a clear top bit. The same holds for a decrementer request raised while disabled and then either kept or dropped by a write.

// File: rtl/exc_pkg.sv
package exc_pkg;

   localparam int NUM_SRC = 7;

   typedef enum logic [2:0] {
      SRC_FETCH = 3'd0,
      SRC_PROG  = 3'd1,
      SRC_FPU   = 3'd2,
      SRC_ALIGN = 3'd3,
      SRC_SC    = 3'd4,
      SRC_EXT   = 3'd5,
      SRC_DEC   = 3'd6
   } exc_src_e;

   localparam int CB_PAGE = 1;
   localparam int CB_DSEG = 3;
   localparam int CB_PROT = 4;
   localparam int CB_ILL  = 12;
   localparam int CB_PRIV = 13;
   localparam int CB_TRAP = 14;

   function automatic logic [11:0] vec_of(input int idx);
      case (idx)
         SRC_FETCH: vec_of = 12'h400;
         SRC_PROG:  vec_of = 12'h700;
         SRC_FPU:   vec_of = 12'h800;
         SRC_ALIGN: vec_of = 12'h600;
         SRC_SC:    vec_of = 12'hC00;
         SRC_EXT:   vec_of = 12'h500;
         SRC_DEC:   vec_of = 12'h900;
         default:   vec_of = 12'h000;
      endcase
   endfunction

endpackage

// File: rtl/exc_fetch_check.sv
module exc_fetch_check
   import exc_pkg::*;
#(
   parameter int CAUSE_W = 32,
   parameter int PP_W    = 2
) (
   input  logic               fetch_valid,
   input  logic               xlate_miss,
   input  logic               dseg,
   input  logic               key,
   input  logic [PP_W-1:0]    pp,
   output logic               req,
   output logic [CAUSE_W-1:0] cause
);

   logic no_read;

   // protection: a set key with an all-zero protection field blocks reads
   assign no_read = key && (pp == '0);

   always_comb begin
      cause = '0;
      if (fetch_valid) begin
         cause[CB_PAGE] = xlate_miss;
         cause[CB_DSEG] = dseg;
         cause[CB_PROT] = no_read;
      end
      req = fetch_valid && (xlate_miss || dseg || no_read);
   end

endmodule

// File: rtl/exc_prog_check.sv
module exc_prog_check
   import exc_pkg::*;
#(
   parameter int CAUSE_W = 32
) (
   input  logic               instr_valid,
   input  logic               msr_pr,
   input  logic               msr_fp,
   input  logic               op_illegal,
   input  logic               op_opt_nop,
   input  logic               op_priv,
   input  logic               op_spr_move,
   input  logic               op_spr_bad,
   input  logic               op_spr_top,
   input  logic               op_trap_hit,
   input  logic               op_fp,
   input  logic               op_misalign,
   input  logic               op_sc,
   output logic               prog_req,
   output logic [CAUSE_W-1:0] prog_cause,
   output logic               fpu_req,
   output logic               align_req,
   output logic               sc_req
);

   logic ill, priv, trap, spr_trip;

   assign spr_trip = op_spr_move && op_spr_bad && op_spr_top;
   assign ill      = instr_valid && op_illegal && !op_opt_nop;
   assign priv     = instr_valid && msr_pr && (op_priv || spr_trip);
   assign trap     = instr_valid && op_trap_hit;

   always_comb begin
      prog_cause          = '0;
      prog_cause[CB_ILL]  = ill;
      prog_cause[CB_PRIV] = priv;
      prog_cause[CB_TRAP] = trap;
   end

   assign prog_req  = ill || priv || trap;
   assign fpu_req   = instr_valid && op_fp && !msr_fp;
   assign align_req = instr_valid && op_misalign;
   assign sc_req    = instr_valid && op_sc;

endmodule

// File: rtl/exc_decrementer.sv
module exc_decrementer #(
   parameter int DEC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr,
   input  logic [DEC_W-1:0] wdata,
   input  logic             grant,
   output logic [DEC_W-1:0] value,
   output logic             pend
);

   localparam logic [DEC_W-1:0] ONE = {{(DEC_W-1){1'b0}}, 1'b1};

   logic [DEC_W-1:0] cnt_q, cnt_nx;
   logic             pend_q, rise;

   assign cnt_nx = cnt_q - ONE;
   assign rise   = tick && !cnt_q[DEC_W-1] && cnt_nx[DEC_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else if (wr) begin
         cnt_q  <= wdata;
         pend_q <= 1'b0;
      end else begin
         if (tick) cnt_q <= cnt_nx;
         if (rise)       pend_q <= 1'b1;
         else if (grant) pend_q <= 1'b0;
      end
   end

   assign value = cnt_q;
   assign pend  = pend_q;

   p_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr) |=> (cnt_q == $past(cnt_q) - ONE));

   p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !grant && !wr) |=> pend_q);

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_pkg::*;
#(
   parameter int N       = NUM_SRC,
   parameter int VEC_W   = 20,
   parameter int CAUSE_W = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N-1:0]                  req,
   input  logic [N-1:0][CAUSE_W-1:0]     cause_in,
   output logic [N-1:0]                  grant,
   output logic                          take_q,
   output logic [VEC_W-1:0]              vec_q,
   output logic [CAUSE_W-1:0]            cause_q
);

   logic [N-1:0][VEC_W-1:0] vec_tab;
   logic [VEC_W-1:0]        vec_sel;
   logic [CAUSE_W-1:0]      cause_sel;

   for (genvar gi = 0; gi < N; gi++) begin : g_vec
      assign vec_tab[gi] = VEC_W'(vec_of(gi));
   end

   // lowest index wins; masked OR keeps the select flat
   always_comb begin
      logic seen;
      seen      = 1'b0;
      vec_sel   = '0;
      cause_sel = '0;
      for (int i = 0; i < N; i++) begin
         grant[i]  = req[i] && !seen;
         seen      = seen || req[i];
         vec_sel   = vec_sel   | (vec_tab[i]  & {VEC_W{grant[i]}});
         cause_sel = cause_sel | (cause_in[i] & {CAUSE_W{grant[i]}});
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take_q  <= 1'b0;
         vec_q   <= '0;
         cause_q <= '0;
      end else begin
         take_q  <= |req;
         vec_q   <= vec_sel;
         cause_q <= cause_sel;
      end
   end

   p_vec_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      take_q |-> (vec_q inside {VEC_W'(12'h400), VEC_W'(12'h500), VEC_W'(12'h600),
                                VEC_W'(12'h700), VEC_W'(12'h800), VEC_W'(12'h900),
                                VEC_W'(12'hC00)}));

   p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !take_q |-> (vec_q == '0 && cause_q == '0));

   p_fetch_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req[SRC_FETCH] |=> (take_q && vec_q == VEC_W'(12'h400)));

endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
   import exc_pkg::*;
#(
   parameter int DEC_W   = 32,
   parameter int VEC_W   = 20,
   parameter int CAUSE_W = 32,
   parameter int PP_W    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fetch_valid_i,
   input  logic               fetch_xlate_miss_i,
   input  logic               fetch_dseg_i,
   input  logic               fetch_key_i,
   input  logic [PP_W-1:0]    fetch_pp_i,
   input  logic               ext_irq_i,
   input  logic               msr_ee_i,
   input  logic               msr_pr_i,
   input  logic               msr_fp_i,
   input  logic               instr_valid_i,
   input  logic               op_illegal_i,
   input  logic               op_opt_nop_i,
   input  logic               op_priv_i,
   input  logic               op_spr_move_i,
   input  logic               op_spr_bad_i,
   input  logic               op_spr_top_i,
   input  logic               op_trap_hit_i,
   input  logic               op_fp_i,
   input  logic               op_misalign_i,
   input  logic               op_sc_i,
   input  logic               dec_tick_i,
   input  logic               dec_wr_i,
   input  logic [DEC_W-1:0]   dec_wdata_i,
   output logic               take_o,
   output logic [VEC_W-1:0]   vec_off_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [DEC_W-1:0]   dec_value_o
);

   if (DEC_W < 2) begin : g_bad_dec
      $error("exc_vector_unit: DEC_W must be at least 2");
   end
   if (VEC_W < 12) begin : g_bad_vec
      $error("exc_vector_unit: VEC_W must hold offset 0xC00");
   end
   if (CAUSE_W <= CB_TRAP) begin : g_bad_cause
      $error("exc_vector_unit: CAUSE_W too narrow for cause bits");
   end

   logic [NUM_SRC-1:0]              req, grant;
   logic [NUM_SRC-1:0][CAUSE_W-1:0] cause_in;
   logic [CAUSE_W-1:0]              fetch_cause, prog_cause;
   logic                            fetch_req, prog_req, fpu_req, align_req, sc_req;
   logic                            dec_pend;

   exc_fetch_check #(.CAUSE_W(CAUSE_W), .PP_W(PP_W)) fetch_i (
      .fetch_valid (fetch_valid_i),
      .xlate_miss  (fetch_xlate_miss_i),
      .dseg        (fetch_dseg_i),
      .key         (fetch_key_i),
      .pp          (fetch_pp_i),
      .req         (fetch_req),
      .cause       (fetch_cause)
   );

   exc_prog_check #(.CAUSE_W(CAUSE_W)) prog_i (
      .instr_valid (instr_valid_i),
      .msr_pr      (msr_pr_i),
      .msr_fp      (msr_fp_i),
      .op_illegal  (op_illegal_i),
      .op_opt_nop  (op_opt_nop_i),
      .op_priv     (op_priv_i),
      .op_spr_move (op_spr_move_i),
      .op_spr_bad  (op_spr_bad_i),
      .op_spr_top  (op_spr_top_i),
      .op_trap_hit (op_trap_hit_i),
      .op_fp       (op_fp_i),
      .op_misalign (op_misalign_i),
      .op_sc       (op_sc_i),
      .prog_req    (prog_req),
      .prog_cause  (prog_cause),
      .fpu_req     (fpu_req),
      .align_req   (align_req),
      .sc_req      (sc_req)
   );

   exc_decrementer #(.DEC_W(DEC_W)) dec_i (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (dec_tick_i),
      .wr    (dec_wr_i),
      .wdata (dec_wdata_i),
      .grant (grant[SRC_DEC]),
      .value (dec_value_o),
      .pend  (dec_pend)
   );

   always_comb begin
      req             = '0;
      req[SRC_FETCH]  = fetch_req;
      req[SRC_PROG]   = prog_req;
      req[SRC_FPU]    = fpu_req;
      req[SRC_ALIGN]  = align_req;
      req[SRC_SC]     = sc_req;
      req[SRC_EXT]    = ext_irq_i && msr_ee_i;
      req[SRC_DEC]    = dec_pend && msr_ee_i;
      cause_in           = '0;
      cause_in[SRC_FETCH] = fetch_cause;
      cause_in[SRC_PROG]  = prog_cause;
   end

   exc_arbiter #(.N(NUM_SRC), .VEC_W(VEC_W), .CAUSE_W(CAUSE_W)) arb_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .cause_in (cause_in),
      .grant    (grant),
      .take_q   (take_o),
      .vec_q    (vec_off_o),
      .cause_q  (cause_o)
   );

   p_ext_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && vec_off_o == VEC_W'(12'h500)) |-> $past(msr_ee_i && ext_irq_i));

   p_fp_never_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && vec_off_o == VEC_W'(12'h800)) |-> !$past(msr_fp_i));

endmodule

// File: tb/exc_vector_unit_tb.sv
module exc_vector_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_valid_i, fetch_xlate_miss_i, fetch_dseg_i, fetch_key_i;
   logic [1:0]  fetch_pp_i;
   logic        ext_irq_i, msr_ee_i, msr_pr_i, msr_fp_i, instr_valid_i;
   logic        op_illegal_i, op_opt_nop_i, op_priv_i, op_spr_move_i, op_spr_bad_i;
   logic        op_spr_top_i, op_trap_hit_i, op_fp_i, op_misalign_i, op_sc_i;
   logic        dec_tick_i, dec_wr_i;
   logic [31:0] dec_wdata_i;
   logic        take_o;
   logic [19:0] vec_off_o;
   logic [31:0] cause_o, dec_value_o;

   int checks = 0;
   int bad    = 0;
   bit done   = 0;
   bit live   = 0;

   always #5 clk = ~clk;

   exc_vector_unit dut_i (.*);

   // behavioural reference
   logic [31:0] m_dec = 0;
   bit          m_pend = 0;
   bit          e_take = 0;
   logic [19:0] e_vec = 0;
   logic [31:0] e_cause = 0;

   always @(posedge clk) begin
      bit fa, pr, fu, al, sc, ex, dc, prot;
      logic [31:0] fc, pc, nd;
      if (!rst_n) begin
         m_dec = 0; m_pend = 0; e_take = 0; e_vec = 0; e_cause = 0;
      end else begin
         prot = fetch_key_i && fetch_pp_i == 2'b00;
         fa = fetch_valid_i && (fetch_xlate_miss_i || fetch_dseg_i || prot);
         fc = 0;
         if (fetch_valid_i) begin
            fc[1] = fetch_xlate_miss_i; fc[3] = fetch_dseg_i; fc[4] = prot;
         end
         pc = 0;
         if (instr_valid_i) begin
            pc[12] = op_illegal_i && !op_opt_nop_i;
            pc[13] = msr_pr_i && (op_priv_i || (op_spr_move_i && op_spr_bad_i && op_spr_top_i));
            pc[14] = op_trap_hit_i;
         end
         pr = pc != 0;
         fu = instr_valid_i && op_fp_i && !msr_fp_i;
         al = instr_valid_i && op_misalign_i;
         sc = instr_valid_i && op_sc_i;
         ex = ext_irq_i && msr_ee_i;
         dc = m_pend && msr_ee_i;
         e_take = 1; e_cause = 0;
         if (fa)      begin e_vec = 20'h00400; e_cause = fc; end
         else if (pr) begin e_vec = 20'h00700; e_cause = pc; end
         else if (fu) e_vec = 20'h00800;
         else if (al) e_vec = 20'h00600;
         else if (sc) e_vec = 20'h00C00;
         else if (ex) e_vec = 20'h00500;
         else if (dc) e_vec = 20'h00900;
         else begin e_take = 0; e_vec = 0; end
         dc = dc && !fa && !pr && !fu && !al && !sc && !ex;
         if (dec_wr_i) begin
            m_dec = dec_wdata_i; m_pend = 0;
         end else begin
            nd = m_dec - 1;
            if (dec_tick_i && !m_dec[31] && nd[31]) m_pend = 1;
            else if (dc) m_pend = 0;
            if (dec_tick_i) m_dec = nd;
         end
      end
   end

   function automatic string tag_of(logic [19:0] v);
      case (v)
         20'h00400: return "R2";
         20'h00500: return "R4";
         20'h00600: return "R10";
         20'h00700: return "R5";
         20'h00800: return "R8";
         20'h00900: return "R9";
         20'h00C00: return "R10";
         default:   return "R12";
      endcase
   endfunction

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the model (R1 legal vectors implied)
   always @(negedge clk) begin
      if (live && rst_n) begin
         chk(take_o == e_take, tag_of(e_vec), "take", {31'b0, take_o}, {31'b0, e_take});
         chk(vec_off_o == e_vec, "R1", "vector", {12'b0, vec_off_o}, {12'b0, e_vec});
         chk(cause_o == e_cause, tag_of(e_vec), "cause", cause_o, e_cause);
         chk(dec_value_o == m_dec, "R9", "dec value", dec_value_o, m_dec);
      end
   end

   task automatic idle();
      fetch_valid_i = 0; fetch_xlate_miss_i = 0; fetch_dseg_i = 0; fetch_key_i = 0;
      fetch_pp_i = 2'b10; ext_irq_i = 0; instr_valid_i = 0;
      op_illegal_i = 0; op_opt_nop_i = 0; op_priv_i = 0; op_spr_move_i = 0;
      op_spr_bad_i = 0; op_spr_top_i = 0; op_trap_hit_i = 0; op_fp_i = 0;
      op_misalign_i = 0; op_sc_i = 0; dec_tick_i = 0; dec_wr_i = 0; dec_wdata_i = 0;
   endtask

   // apply current inputs for one edge, then sample after it
   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic expect_out(string req, bit tk, logic [19:0] v, logic [31:0] c);
      chk(take_o == tk, req, "take", {31'b0, take_o}, {31'b0, tk});
      chk(vec_off_o == v, req, "vector", {12'b0, vec_off_o}, {12'b0, v});
      chk(cause_o == c, req, "cause", cause_o, c);
   endtask

   task automatic next();
      @(negedge clk); idle();
   endtask

   task summary();
      $display("  test done: total=%0d bad=%0d", checks, bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; bad++;
         $display("FAIL R12 watchdog actual=%h expected=%h", 32'd0, 32'd1);
         summary();
         $finish;
      end
   end

   initial begin
      idle();
      msr_ee_i = 0; msr_pr_i = 0; msr_fp_i = 1;
      repeat (3) @(posedge clk);
      #2;
      // R12: reset state
      expect_out("R12", 0, 0, 0);
      chk(dec_value_o == 0, "R9", "reset dec", dec_value_o, 0);
      @(negedge clk); rst_n = 1; live = 1;
      next();

      // R2 page fault / direct-store / protection
      fetch_valid_i = 1; fetch_xlate_miss_i = 1; step();
      expect_out("R2", 1, 20'h400, 32'h2); next();
      fetch_valid_i = 1; fetch_dseg_i = 1; step();
      expect_out("R2", 1, 20'h400, 32'h8); next();
      // R3 key=1 pp=00 blocks read
      fetch_valid_i = 1; fetch_key_i = 1; fetch_pp_i = 2'b00; step();
      expect_out("R3", 1, 20'h400, 32'h10); next();
      // R3 key=0 pp=00 and key=1 pp=01 allow
      fetch_valid_i = 1; fetch_key_i = 0; fetch_pp_i = 2'b00; step();
      expect_out("R3", 0, 0, 0); next();
      fetch_valid_i = 1; fetch_key_i = 1; fetch_pp_i = 2'b01; step();
      expect_out("R3", 0, 0, 0); next();
      // R2 all bits together; no fetch_valid means nothing
      fetch_valid_i = 1; fetch_xlate_miss_i = 1; fetch_dseg_i = 1; fetch_key_i = 1;
      fetch_pp_i = 2'b00; step();
      expect_out("R2", 1, 20'h400, 32'h1A); next();
      fetch_xlate_miss_i = 1; step();
      expect_out("R2", 0, 0, 0); next();

      // R4 external gating
      ext_irq_i = 1; msr_ee_i = 0; step();
      expect_out("R4", 0, 0, 0); next();
      ext_irq_i = 1; msr_ee_i = 1; step();
      expect_out("R4", 1, 20'h500, 0); next();
      msr_ee_i = 0;

      // R5 illegal, optional no-op excluded
      instr_valid_i = 1; op_illegal_i = 1; step();
      expect_out("R5", 1, 20'h700, 32'h1000); next();
      instr_valid_i = 1; op_illegal_i = 1; op_opt_nop_i = 1; step();
      expect_out("R5", 0, 0, 0); next();

      // R6 privileged and bad special-register moves
      instr_valid_i = 1; op_priv_i = 1; msr_pr_i = 0; step();
      expect_out("R6", 0, 0, 0); next();
      instr_valid_i = 1; op_priv_i = 1; msr_pr_i = 1; step();
      expect_out("R6", 1, 20'h700, 32'h2000); next();
      instr_valid_i = 1; op_spr_move_i = 1; op_spr_bad_i = 1; op_spr_top_i = 1; step();
      expect_out("R6", 1, 20'h700, 32'h2000); next();
      instr_valid_i = 1; op_spr_move_i = 1; op_spr_bad_i = 1; op_spr_top_i = 0; step();
      expect_out("R6", 0, 0, 0); next();
      instr_valid_i = 1; op_spr_move_i = 1; op_spr_bad_i = 0; op_spr_top_i = 1; step();
      expect_out("R6", 0, 0, 0); next();
      msr_pr_i = 0;

      // R7 trap, and combined program causes
      instr_valid_i = 1; op_trap_hit_i = 1; step();
      expect_out("R7", 1, 20'h700, 32'h4000); next();
      instr_valid_i = 1; op_trap_hit_i = 1; op_illegal_i = 1; step();
      expect_out("R7", 1, 20'h700, 32'h5000); next();

      // R8 floating-point unavailable
      instr_valid_i = 1; op_fp_i = 1; msr_fp_i = 1; step();
      expect_out("R8", 0, 0, 0); next();
      instr_valid_i = 1; op_fp_i = 1; msr_fp_i = 0; step();
      expect_out("R8", 1, 20'h800, 0); next();

      // R10 alignment and system call
      instr_valid_i = 1; op_misalign_i = 1; step();
      expect_out("R10", 1, 20'h600, 0); next();
      instr_valid_i = 1; op_sc_i = 1; step();
      expect_out("R10", 1, 20'hC00, 0); next();

      // R11 priority walk, msr_fp_i=0 still
      msr_ee_i = 1; msr_pr_i = 0;
      fetch_valid_i = 1; fetch_xlate_miss_i = 1; instr_valid_i = 1; op_illegal_i = 1;
      op_fp_i = 1; op_misalign_i = 1; op_sc_i = 1; ext_irq_i = 1; step();
      expect_out("R11", 1, 20'h400, 32'h2); next();
      instr_valid_i = 1; op_illegal_i = 1; op_fp_i = 1; op_misalign_i = 1; op_sc_i = 1;
      ext_irq_i = 1; step();
      expect_out("R11", 1, 20'h700, 32'h1000); next();
      instr_valid_i = 1; op_fp_i = 1; op_misalign_i = 1; op_sc_i = 1; ext_irq_i = 1; step();
      expect_out("R11", 1, 20'h800, 0); next();
      instr_valid_i = 1; op_misalign_i = 1; op_sc_i = 1; ext_irq_i = 1; step();
      expect_out("R11", 1, 20'h600, 0); next();
      instr_valid_i = 1; op_sc_i = 1; ext_irq_i = 1; step();
      expect_out("R11", 1, 20'hC00, 0); next();
      msr_fp_i = 1; msr_ee_i = 0;

      // R9 decrementer: load 1, two ticks -> top bit rises, enable off
      dec_wr_i = 1; dec_wdata_i = 32'd1; step();
      chk(dec_value_o == 1, "R9", "load", dec_value_o, 1); next();
      dec_tick_i = 1; step(); next();
      dec_tick_i = 1; step();
      chk(dec_value_o == 32'hFFFF_FFFF, "R9", "wrap", dec_value_o, 32'hFFFF_FFFF); next();
      repeat (3) begin step(); expect_out("R9", 0, 0, 0); next(); end
      // held request taken once enable rises; lower than external (R11)
      msr_ee_i = 1; ext_irq_i = 1; step();
      expect_out("R11", 1, 20'h500, 0); next();
      msr_ee_i = 1; step();
      expect_out("R9", 1, 20'h900, 0); next();
      msr_ee_i = 1; step();
      expect_out("R9", 0, 0, 0); next();
      // R9 write drops a pending request
      msr_ee_i = 0;
      dec_wr_i = 1; dec_wdata_i = 32'd0; step(); next();
      dec_tick_i = 1; step(); next();
      dec_wr_i = 1; dec_wdata_i = 32'h0000_0010; step(); next();
      msr_ee_i = 1;
      repeat (3) begin step(); expect_out("R9", 0, 0, 0); next(); end
      // R9 ticks counting over several cycles
      repeat (5) begin dec_tick_i = 1; step(); next(); end
      chk(dec_value_o == 32'h0000_000B, "R9", "count", dec_value_o, 32'h0000_000B);

      repeat (4) next();
      done = 1;
      summary();
      $finish;
   end

endmodule